// File: doc/BRIEF.md
# Five-Tap Filter Edge Mirror

This block sits in front of a five-tap FIR filter and turns a stream of samples along one window into a set of five tap values for each output position. The same logic serves horizontal filtering, where the samples are pixels, and vertical filtering, where they are lines. Output position p needs the samples at positions p-2 through p+2. Near an edge of the window those neighbours may lie outside the image. When that edge lies on the image boundary, software enables mirroring for that edge, and the block then makes up the missing neighbours by reflecting about the edge sample. The edge sample itself is not repeated.

The caller sets the window length N and the two mirror enables, then streams samples with a valid strobe. With start mirroring off, the stream begins with the two real samples at positions -2 and -1. With end mirroring off, the stream ends with the two real samples at positions N and N+1. With end mirroring on, the last two tap sets come out in the two cycles after sample N-1 is accepted, and no further input is needed. The block also reports the output position, which the filter can use to select coefficients.

Top module: `edge_mirror_taps`

## Requirements
- R1: After reset, `taps_vld_o` is 0 and `pos_o` is 0.
- R2: With both mirror enables low, the block accepts N+4 samples for positions -2 to N+1. Output position p becomes valid in the cycle after the sample at position p+2 is accepted, and every tap is the real sample.
- R3: With start mirroring on, the first sample accepted is position 0. Position -1 is replaced by sample 1 and position -2 by sample 2, so position 0 gives taps (s2,s1,s0,s1,s2) and position 1 gives (s1,s0,s1,s2,s3).
- R4: With end mirroring on, the last sample accepted is position N-1. Positions N-2 and N-1 are produced in the next two consecutive cycles, with position N replaced by sample N-2 and position N+1 by sample N-3.
- R5: The minimum length N=4 works with both mirror enables on.
- R6: When `len_i` is below 4, `len_err_o` is 1, no window starts, incoming samples are ignored and `taps_vld_o` stays 0.
- R7: Each window raises `taps_vld_o` for exactly N single cycles. `pos_o` takes the values 0 to N-1 in ascending order, and `pos_o` is always less than N while valid.
- R8: The length and both enables are captured with the first sample of a window. Changes to them later in that window have no effect on its outputs.
- R9: Samples presented during the two end-mirror output cycles are ignored and do not start a new window.
- R10: Tap j of the output (bits j*DW+DW-1 down to j*DW of `taps_o`, j = 0 to 4) holds the sample for position `pos_o`+j-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | DW | Sample data |
| smp_vld_i | input | 1 | Sample valid |
| len_i | input | LW | Window length N in output positions |
| start_mir_i | input | 1 | Mirror the samples before position 0 |
| end_mir_i | input | 1 | Mirror the samples after position N-1 |
| taps_o | output | 5*DW | Five tap values, tap 0 is position p-2 |
| taps_vld_o | output | 1 | Tap set valid |
| pos_o | output | LW | Output position p of the current tap set |
| len_err_o | output | 1 | Length below the minimum of 4 |

## Verification
Assertions check the following on every cycle: the reflection symmetry of the tap set at position 0 under start mirroring, and at position N-1 under end mirroring; that each tail cycle produces an output; that `pos_o` stays below the captured length; that the captured settings hold steady while a window fills; that no window starts while the length is in error; and that the sample window shifts correctly. Other properties can only be shown by the bench scenarios: that each tap value equals the reference sample for every position and every combination of enables, that each window produces exactly N outputs, that settings changed in mid-window are ignored, and that a sample presented during the tail is dropped.

// File: rtl/edge_mirror_pkg.sv
package edge_mirror_pkg;
  localparam int NTAP = 5;
  localparam int HALF = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_TAIL
  } mir_st_e;

  // source of the value shifted into the sample window
  typedef enum logic [1:0] {
    INS_NEW,
    INS_NEAR,
    INS_FAR
  } ins_e;
endpackage

// File: rtl/edge_tap_shift.sv
module edge_tap_shift #(
  parameter int DW    = 8,
  parameter int DEPTH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DW-1:0]     din_i,
  output logic [DEPTH*DW-1:0] win_o
);
  logic [DW-1:0] stg_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stg_q[i] <= '0;
        else if (shift_i) stg_q[i] <= (i == 0) ? din_i : stg_q[(i == 0) ? 0 : i-1];
      end
      assign win_o[i*DW +: DW] = stg_q[i];
    end
  endgenerate

  // R10
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (win_o[DW +: DW] == $past(win_o[0 +: DW])));
endmodule

// File: rtl/edge_mirror_ctrl.sv
module edge_mirror_ctrl
  import edge_mirror_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [LW-1:0] len_i,
  input  logic          start_mir_i,
  input  logic          end_mir_i,
  output logic          shift_o,
  output ins_e          ins_o,
  output logic          vld_o,
  output logic [LW-1:0] pos_o,
  output logic          sm_o,
  output logic          em_o,
  output logic [LW-1:0] len_o,
  output logic          err_o
);
  localparam int CW = LW + 2;

  mir_st_e       st_q;
  logic [CW-1:0] idx_q;
  logic [LW-1:0] len_q, mir_end_q, pos_q;
  logic          sm_q, em_q, vld_q;

  logic          idle, acc, cur_sm, cur_em, emit, last, tail_more;
  logic [LW-1:0] cur_len;
  logic [CW-1:0] k, lead, tot;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    err_o     = (len_i < LW'(4));
    acc       = smp_vld_i && (idle ? !err_o : (st_q == ST_FILL));
    cur_len   = idle ? len_i : len_q;
    cur_sm    = idle ? start_mir_i : sm_q;
    cur_em    = idle ? end_mir_i : em_q;
    k         = idle ? '0 : idx_q;
    lead      = cur_sm ? '0 : CW'(HALF);
    tot       = CW'(cur_len) + (cur_sm ? '0 : CW'(HALF)) + (cur_em ? '0 : CW'(HALF));
    emit      = (k >= lead + CW'(HALF));
    last      = (k == tot - CW'(1));
    // mirror counter (output position) against mirror-end value
    tail_more = ((pos_q + LW'(1)) == mir_end_q);
    shift_o   = acc || (st_q == ST_TAIL);
    if (st_q == ST_TAIL) ins_o = tail_more ? INS_NEAR : INS_FAR;
    else                 ins_o = INS_NEW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      len_q     <= '0;
      mir_end_q <= '0;
      pos_q     <= '0;
      sm_q      <= 1'b0;
      em_q      <= 1'b0;
      vld_q     <= 1'b0;
    end else if (acc) begin
      if (idle) begin
        len_q     <= len_i;
        mir_end_q <= len_i - LW'(2);
        sm_q      <= start_mir_i;
        em_q      <= end_mir_i;
      end
      vld_q <= emit;
      if (emit) pos_q <= LW'(k - lead - CW'(HALF));
      if (last) begin
        st_q  <= cur_em ? ST_TAIL : ST_IDLE;
        idx_q <= '0;
      end else begin
        st_q  <= ST_FILL;
        idx_q <= k + CW'(1);
      end
    end else if (st_q == ST_TAIL) begin
      vld_q <= 1'b1;
      pos_q <= pos_q + LW'(1);
      if (!tail_more) st_q <= ST_IDLE;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign pos_o = pos_q;
  assign sm_o  = sm_q;
  assign em_o  = em_q;
  assign len_o = len_q;

  // R7
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (pos_q < len_q));
  // R4
  tail_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL) |=> vld_q);
  // R6
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && err_o) |=> ((st_q == ST_IDLE) && !vld_q));
  // R8
  latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL) |=> ($stable(len_q) && $stable(sm_q) && $stable(em_q)));
endmodule

// File: rtl/edge_tap_sel.sv
module edge_tap_sel
  import edge_mirror_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NTAP*DW-1:0]   win_i,
  input  logic [LW-1:0]        pos_i,
  input  logic                 sm_i,
  input  logic                 vld_i,
  output logic [NTAP*DW-1:0]   taps_o
);
  logic [DW-1:0] tap [NTAP];

  always_comb begin
    for (int j = 0; j < NTAP; j++) tap[j] = win_i[(NTAP-1-j)*DW +: DW];
    // start-edge reflection: window holds s2,s1,s0 (pos 0) or s3..s0 (pos 1)
    if (sm_i && pos_i == '0) begin
      tap[0] = win_i[0 +: DW];
      tap[1] = win_i[DW +: DW];
    end else if (sm_i && pos_i == LW'(1)) begin
      tap[0] = win_i[2*DW +: DW];
    end
  end

  generate
    for (genvar j = 0; j < NTAP; j++) begin : g_pack
      assign taps_o[j*DW +: DW] = tap[j];
    end
  endgenerate

  // R3
  start_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sm_i && pos_i == '0) |->
      (taps_o[0 +: DW] == taps_o[4*DW +: DW] && taps_o[DW +: DW] == taps_o[3*DW +: DW]));
endmodule

// File: rtl/edge_mirror_taps.sv
module edge_mirror_taps
  import edge_mirror_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DW-1:0]      smp_i,
  input  logic               smp_vld_i,
  input  logic [LW-1:0]      len_i,
  input  logic               start_mir_i,
  input  logic               end_mir_i,
  output logic [NTAP*DW-1:0] taps_o,
  output logic               taps_vld_o,
  output logic [LW-1:0]      pos_o,
  output logic               len_err_o
);
  logic [NTAP*DW-1:0] win;
  logic [DW-1:0]      din;
  logic               shift, sm_l, em_l;
  ins_e               ins;
  logic [LW-1:0]      len_l;

  edge_mirror_ctrl #(.LW(LW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_vld_i   (smp_vld_i),
    .len_i       (len_i),
    .start_mir_i (start_mir_i),
    .end_mir_i   (end_mir_i),
    .shift_o     (shift),
    .ins_o       (ins),
    .vld_o       (taps_vld_o),
    .pos_o       (pos_o),
    .sm_o        (sm_l),
    .em_o        (em_l),
    .len_o       (len_l),
    .err_o       (len_err_o)
  );

  // tail reflection: re-insert sample N-2 then N-3 from the window
  always_comb begin
    case (ins)
      INS_NEAR: din = win[DW +: DW];
      INS_FAR:  din = win[3*DW +: DW];
      default:  din = smp_i;
    endcase
  end

  edge_tap_shift #(.DW(DW), .DEPTH(NTAP)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .din_i   (din),
    .win_o   (win)
  );

  edge_tap_sel #(.DW(DW), .LW(LW)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win),
    .pos_i  (pos_o),
    .sm_i   (sm_l),
    .vld_i  (taps_vld_o),
    .taps_o (taps_o)
  );

  // R4
  end_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taps_vld_o && em_l && pos_o == len_l - LW'(1)) |->
      (taps_o[3*DW +: DW] == taps_o[DW +: DW] && taps_o[4*DW +: DW] == taps_o[0 +: DW]));
endmodule

// File: tb/sim_edge_mirror_taps.sv
module sim_edge_mirror_taps;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int LW = 8;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] smp = '0;
  logic smp_vld = 0;
  logic [LW-1:0] len = 8'd8;
  logic smir = 0, emir = 0;
  logic [5*DW-1:0] taps;
  logic taps_vld, len_err;
  logic [LW-1:0] pos;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] ref_s [0:80];
  int w_n = 0;
  bit w_sm = 0, w_em = 0, expecting = 0;
  int got = 0, exp_pos = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  edge_mirror_taps #(.DW(DW), .LW(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(smp_vld), .len_i(len),
    .start_mir_i(smir), .end_mir_i(emir), .taps_o(taps), .taps_vld_o(taps_vld),
    .pos_o(pos), .len_err_o(len_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_smp(input int p);
    if (p < 0 && w_sm) return int'(ref_s[-p + 2]);
    if (p >= w_n && w_em) return int'(ref_s[2*w_n - 2 - p + 2]);
    return int'(ref_s[p + 2]);
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (rst_n && taps_vld && !done) begin
      if (!expecting) chk(0, "R6 unexpected valid", 1, 0);
      else begin
        chk(int'(pos) == exp_pos, "R7 position", int'(pos), exp_pos);
        for (int j = 0; j < 5; j++) begin
          string tag;
          if (w_sm && exp_pos < 2) tag = "R3 start tap";
          else if (w_em && exp_pos >= w_n - 2) tag = "R4 end tap";
          else tag = "R2/R10 tap";
          chk(int'(taps[j*DW +: DW]) == exp_smp(exp_pos + j - 2), tag,
              int'(taps[j*DW +: DW]), exp_smp(exp_pos + j - 2));
        end
        got++;
        exp_pos++;
      end
    end
  end

  task automatic run_win(input int n, input bit sm, input bit em, input int gapmax,
                         input bit scramble, input bit junk);
    int first, last;
    w_n = n; w_sm = sm; w_em = em;
    for (int i = 0; i < n + 4; i++) ref_s[i] = DW'($urandom);
    got = 0; exp_pos = 0; expecting = 1;
    @(negedge clk);
    len = LW'(n); smir = sm; emir = em;
    first = sm ? 0 : -2;
    last  = em ? n - 1 : n + 1;
    for (int p = first; p <= last; p++) begin
      int g = (gapmax > 0) ? $urandom_range(0, gapmax) : 0;
      for (int c = 0; c < g; c++) begin
        smp_vld = 0; smp = DW'($urandom);
        @(negedge clk);
      end
      smp_vld = 1; smp = ref_s[p + 2];
      if (scramble && p != first) begin  // R8 mid-window changes
        len = LW'($urandom_range(4, 60)); smir = ~sm; emir = ~em;
      end
      @(negedge clk);
    end
    smp_vld = junk; smp = DW'($urandom);  // R9 sample during tail
    @(negedge clk);
    smp_vld = 0;
    len = LW'(n); smir = sm; emir = em;
    repeat (6) @(negedge clk);
    chk(got == n, "R7 output count", got, n);
    expecting = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        chk(0, "watchdog", cyc, 150000);
        finish_up();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(taps_vld == 0, "R1 reset valid", int'(taps_vld), 0);
    chk(pos == 0, "R1 reset position", int'(pos), 0);
    len = 8'd4;
    #1 chk(len_err == 0, "R6 length 4 accepted", int'(len_err), 0);
    // directed corners
    run_win(4, 1, 1, 0, 0, 0);   // R5
    run_win(4, 0, 0, 0, 0, 0);   // R2
    run_win(5, 1, 0, 1, 0, 0);   // R3
    run_win(6, 0, 1, 1, 0, 0);   // R4
    run_win(7, 1, 1, 2, 1, 0);   // R8
    run_win(5, 0, 1, 0, 0, 1);   // R9
    run_win(6, 1, 0, 0, 0, 0);   // R9 follow-up: alignment intact
    // R6: short length
    @(negedge clk);
    len = 8'd3; expecting = 0;
    #1 chk(len_err == 1, "R6 error flag", int'(len_err), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); smp_vld = 1; smp = DW'($urandom);
    end
    @(negedge clk); smp_vld = 0;
    repeat (4) @(negedge clk);
    chk(taps_vld == 0, "R6 no output", int'(taps_vld), 0);
    run_win(4, 0, 1, 0, 0, 0);   // R6 recovery
    // random windows
    for (int w = 0; w < 24; w++)
      run_win($urandom_range(4, 40), 1'($urandom), 1'($urandom), 3, 0, 0);
    finish_up();
  end
endmodule